// File: doc/BRIEF.md
# Pipelined AHB-Lite Memory Slave

This block is a small word-organised memory that sits on an AHB-Lite bus as a slave. The bus is pipelined: the address and control of a transfer come in one cycle, and the data for that transfer comes in the next cycle. The block keeps the two apart. It registers the address-phase context (valid flag, address, direction, size) and uses only that registered copy to steer the data phase. It never uses the address currently on the bus for this. Because of this, each data beat lands on, or is read from, the address it was issued with. This holds with back-to-back traffic, with a read directly after a write to the same word, and with wait states.

Each accepted transfer gets a fixed number of wait cycles, set by a parameter. During those cycles the slave holds its ready output low, then raises it for one cycle to complete the beat. The stored context is only reloaded in a cycle where the bus-wide ready is high. The next master's address can sit on the bus through the whole stall without disturbing the pending beat. Writes support byte, halfword and word sizes with per-lane enables. Every response is OKAY.

Top module: `ahb_mem_slave`

## Requirements
- R1: A transfer is accepted only when `hsel` is high and `htrans` is NONSEQ (2'b10) or SEQ (2'b11), sampled in a cycle where `hready` is high.
- R2: An IDLE (2'b00) or BUSY (2'b01) transfer, or any transfer with `hsel` low, gives a data phase that completes at once (`hreadyout` high), writes nothing whatever `hwrite`/`hwdata` are, and returns `hrdata` of zero.
- R3: While a data phase is stalled (`hready` low), a different address and control presented on the bus do not replace the stored context. The stalled beat still uses its own address.
- R4: A write changes storage only in the completing cycle of its data phase. It uses the captured address and the `hwdata` present in that cycle. Nothing is written during the address phase.
- R5: Every accepted transfer's data phase holds `hreadyout` low for exactly `WAIT_CYCLES` cycles, then high for one cycle.
- R6: A read returns, in the completing cycle of its data phase, the full stored word at its captured address. `hrdata` is zero in every other cycle.
- R7: In back-to-back transfers, the cycle that is B's address phase and A's data phase acts on A's address. A read right after a write to the same word returns the new data, and a read right before a write returns the old data.
- R8: `hsize` 0, 1 and 2 write 1, 2 and 4 bytes. The active lanes are those whose lane number shifted right by `hsize` equals `haddr[1:0]` shifted right by `hsize`. Other lanes keep their value.
- R9: `hresp` is always 0 (OKAY).
- R10: After reset, no transfer is pending, `hreadyout` is high, and every stored word reads as zero.
- R11: The word index is `haddr[5:2]` for the default 16-word depth. Higher address bits are ignored, so addresses 64 bytes apart alias.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Slave select for the current address phase |
| haddr | input | ADDR_W | Byte address of the current address phase |
| htrans | input | 2 | Transfer type (IDLE, BUSY, NONSEQ, SEQ) |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size code (bytes = 2^hsize) |
| hwdata | input | DATA_W | Write data of the current data phase |
| hready | input | 1 | Bus-wide ready; high ends the current data phase |
| hreadyout | output | 1 | This slave's ready for its data phase |
| hrdata | output | DATA_W | Read data of the current data phase |
| hresp | output | 1 | Response, always OKAY (0) |

## Verification
The bench drives fully pipelined traffic. The next transfer's address sits on the bus through every wait state, so a slave that reloads its context while stalled would write the stalled beat's data to the next address, or read from it. Directed pairs cover a write followed at once by a read of the same word, and a read followed by a write. A slave that writes in the address phase, or that steers with the live address, would return stale or future data there. Idle, busy and deselected beats carry junk write data to catch a write that leaks through. Aliased addresses and narrow writes on every lane check the index slice and lane enables, and wait counts are checked on every beat.

// File: rtl/ahb_mem_pkg.sv
// Shared encodings for the AHB-Lite memory slave.
// Assumes the standard two-bit transfer type coding.
package ahb_mem_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'b00,
        TR_BUSY   = 2'b01,
        TR_NONSEQ = 2'b10,
        TR_SEQ    = 2'b11
    } htrans_e;

    // True for transfer types that carry data (NONSEQ and SEQ).
    function automatic logic moves_data(input logic [1:0] trans);
        return (trans == TR_NONSEQ) || (trans == TR_SEQ);
    endfunction

endpackage

// File: rtl/ahb_addr_capture.sv
// Address-phase context register.
// Holds valid/write/size/address of the transfer whose data phase is next.
// Reloads only when the bus-wide ready is high, so a stall keeps the pending
// context. Assumes the caller supplies hready as seen by all slaves.
module ahb_addr_capture
    import ahb_mem_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel_i,
    input  logic [1:0]        htrans_i,
    input  logic              hwrite_i,
    input  logic [2:0]        hsize_i,
    input  logic [ADDR_W-1:0] haddr_i,
    input  logic              hready_i,
    output logic              ctx_valid_o,
    output logic              ctx_write_o,
    output logic [2:0]        ctx_size_o,
    output logic [ADDR_W-1:0] ctx_addr_o
);

    // Load the context at the end of each address phase; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_valid_o <= 1'b0;
            ctx_write_o <= 1'b0;
            ctx_size_o  <= '0;
            ctx_addr_o  <= '0;
        end else if (hready_i) begin
            ctx_valid_o <= hsel_i && moves_data(htrans_i);
            ctx_write_o <= hwrite_i;
            ctx_size_o  <= hsize_i;
            ctx_addr_o  <= haddr_i;
        end
    end

    // R3: a stalled cycle leaves the stored context untouched.
    a_r3_hold_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !hready_i |=> $stable({ctx_valid_o, ctx_write_o, ctx_size_o, ctx_addr_o}));

endmodule

// File: rtl/ahb_wait_ctrl.sv
// Wait-state generator for the data phase.
// Counts WAIT_CYCLES stalled cycles for a valid context, then signals ready.
// Assumes hready_i is low whenever ready_o is low (this slave owns the beat).
module ahb_wait_ctrl #(
    parameter int WAIT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hready_i,
    input  logic ctx_valid_i,
    output logic ready_o
);

    localparam int CNT_W = (WAIT_CYCLES < 1) ? 1 : $clog2(WAIT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Restart the count on each new address phase, step it while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hready_i) begin
            cnt_q <= '0;
        end else if (ctx_valid_i && (cnt_q != CNT_LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Ready once the wait budget is spent, or at once for a no-op phase.
    always_comb begin
        ready_o = !ctx_valid_i || (cnt_q == CNT_LAST);
    end

    // R2: a phase with no accepted transfer never stalls.
    a_r2_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !ctx_valid_i |-> ready_o);

    // R5: the counter never runs past the programmed wait budget.
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

    // R5: a stalled valid beat is still pending in the next cycle.
    a_r5_stall_keeps_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_valid_i && !ready_o) |=> ctx_valid_i);

endmodule

// File: rtl/ahb_word_store.sv
// Register-array storage with byte-lane write enables.
// One array per byte lane, built by generate; reset clears every byte.
// Assumes DATA_W is a multiple of 8 and DEPTH is a power of two.
module ahb_word_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [$clog2(DEPTH)-1:0] wr_idx_i,
    input  logic [DATA_W/8-1:0]    wr_be_i,
    input  logic [DATA_W-1:0]      wr_data_i,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
    output logic [DATA_W-1:0]      rd_data_o
);

    localparam int LANES = DATA_W / 8;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] bytes_q [DEPTH];

        // Clear on reset, otherwise write this lane when enabled.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < DEPTH; w++) begin
                    bytes_q[w] <= 8'h00;
                end
            end else if (wr_en_i && wr_be_i[g]) begin
                bytes_q[wr_idx_i] <= wr_data_i[g*8 +: 8];
            end
        end

        // Asynchronous read of this lane.
        always_comb begin
            rd_data_o[g*8 +: 8] = bytes_q[rd_idx_i];
        end
    end

    // R8: a write always enables at least one lane.
    a_r8_lane_present: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |-> (wr_be_i != '0));

endmodule

// File: rtl/ahb_mem_slave.sv
// AHB-Lite memory slave top.
// Pairs each data phase with the context captured in its address phase,
// inserts WAIT_CYCLES wait states per accepted beat, and always answers OKAY.
// Assumes aligned transfers no wider than DATA_W and a power-of-two DEPTH.
module ahb_mem_slave #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int DEPTH       = 16,
    parameter int WAIT_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic              hreadyout,
    output logic [DATA_W-1:0] hrdata,
    output logic              hresp
);

    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int KEEP_W = OFF_W + IDX_W;

    logic              ctx_valid;
    logic              ctx_write;
    logic [2:0]        ctx_size;
    logic [ADDR_W-1:0] ctx_addr;
    logic              slave_ready;
    logic              commit;
    logic [IDX_W-1:0]  word_idx;
    logic [OFF_W-1:0]  byte_off;
    logic [LANES-1:0]  lane_be;
    logic [DATA_W-1:0] store_rd;
    logic              unused_addr_hi;

    ahb_addr_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .hsel_i      (hsel),
        .htrans_i    (htrans),
        .hwrite_i    (hwrite),
        .hsize_i     (hsize),
        .haddr_i     (haddr),
        .hready_i    (hready),
        .ctx_valid_o (ctx_valid),
        .ctx_write_o (ctx_write),
        .ctx_size_o  (ctx_size),
        .ctx_addr_o  (ctx_addr)
    );

    ahb_wait_ctrl #(.WAIT_CYCLES(WAIT_CYCLES)) u_wait (
        .clk         (clk),
        .rst_n       (rst_n),
        .hready_i    (hready),
        .ctx_valid_i (ctx_valid),
        .ready_o     (slave_ready)
    );

    // Split the captured address into word index and byte offset.
    always_comb begin
        word_idx = ctx_addr[KEEP_W-1:OFF_W];
        byte_off = ctx_addr[OFF_W-1:0];
    end

    assign unused_addr_hi = ^ctx_addr[ADDR_W-1:KEEP_W];

    // Lane enables: a lane is active when it shares the size-aligned group of the offset.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            lane_be[l] = ((l >> ctx_size) == (int'(byte_off) >> ctx_size));
        end
    end

    // Commit a write only in the completing cycle of its data phase.
    always_comb begin
        commit = ctx_valid && ctx_write && slave_ready;
    end

    ahb_word_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (commit),
        .wr_idx_i  (word_idx),
        .wr_be_i   (lane_be),
        .wr_data_i (hwdata),
        .rd_idx_i  (word_idx),
        .rd_data_o (store_rd)
    );

    // Drive outputs: read data only in a completing read beat, response always OKAY.
    always_comb begin
        hreadyout = slave_ready;
        hrdata    = (ctx_valid && !ctx_write && slave_ready) ? store_rd : '0;
        hresp     = 1'b0;
    end

    // R6: read data stays zero while the beat is stalled.
    a_r6_rdata_quiet_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !hreadyout |-> (hrdata == '0));

    // R4: storage is never written while the slave is stalling the bus.
    a_r4_no_write_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !hreadyout |-> !u_store.wr_en_i);

endmodule

// File: tb/ahb_mem_slave_bench.sv
module ahb_mem_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 16;
    localparam int WAITS  = 2;
    localparam int QMAX   = 512;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              hsel;
    logic [ADDR_W-1:0] haddr;
    logic [1:0]        htrans;
    logic              hwrite;
    logic [2:0]        hsize;
    logic [DATA_W-1:0] hwdata;
    logic              hready;
    logic              hreadyout;
    logic [DATA_W-1:0] hrdata;
    logic              hresp;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign hready = hreadyout;

    ahb_mem_slave #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .WAIT_CYCLES(WAITS))
    u_ahb_mem_slave (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
        .hreadyout(hreadyout), .hrdata(hrdata), .hresp(hresp)
    );

    logic [DATA_W-1:0] model [DEPTH];

    logic              q_sel   [QMAX];
    logic [1:0]        q_trans [QMAX];
    logic              q_wr    [QMAX];
    logic [2:0]        q_size  [QMAX];
    logic [ADDR_W-1:0] q_addr  [QMAX];
    logic [DATA_W-1:0] q_wdata [QMAX];
    string             q_tag   [QMAX];
    int nq = 0;

    task automatic check(input bit ok, input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int widx(input logic [ADDR_W-1:0] a);
        return int'(a[5:2]);
    endfunction

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
        input logic [DATA_W-1:0] wd, input logic [2:0] sz, input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] r;
        r = old;
        for (int l = 0; l < 4; l++)
            if ((l >> sz) == (int'(a[1:0]) >> sz)) r[l*8 +: 8] = wd[l*8 +: 8];
        return r;
    endfunction

    task automatic push(input logic s, input logic [1:0] t, input logic w, input logic [2:0] z,
                        input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string tag);
        q_sel[nq] = s; q_trans[nq] = t; q_wr[nq] = w; q_size[nq] = z;
        q_addr[nq] = a; q_wdata[nq] = d; q_tag[nq] = tag;
        nq++;
    endtask

    // Run the queued transfers fully pipelined, checking each data phase.
    task automatic flush();
        bit pv = 0; bit pw = 0; logic [2:0] pz = 0; logic [ADDR_W-1:0] pa = 0;
        logic [DATA_W-1:0] pd = 0; string ptag = "R6";
        for (int i = 0; i <= nq; i++) begin
            int waits = 0;
            bit rdy = 0;
            @(negedge clk);
            if (i < nq) begin
                hsel = q_sel[i]; htrans = q_trans[i]; hwrite = q_wr[i];
                hsize = q_size[i]; haddr = q_addr[i];
            end else begin
                hsel = 0; htrans = 2'b00; hwrite = 0; hsize = 0; haddr = $urandom;
            end
            hwdata = (pv && pw) ? pd : $urandom;
            while (!rdy) begin
                #1;
                if (hreadyout) rdy = 1;
                else begin waits++; @(posedge clk); @(negedge clk); end
            end
            check(waits == (pv ? WAITS : 0), pv ? "R5 wait count" : "R2 no-op wait count",
                  waits, pv ? WAITS : 0);
            check(hresp == 1'b0, "R9 response", hresp, 0);
            if (pv && !pw)
                check(hrdata == model[widx(pa)], ptag, hrdata, model[widx(pa)]);
            else
                check(hrdata == '0, "R2/R6 rdata zero", hrdata, 0);
            if (pv && pw) model[widx(pa)] = merge(model[widx(pa)], pd, pz, pa);
            if (i < nq) begin
                pv = q_sel[i] && q_trans[i][1]; pw = q_wr[i]; pz = q_size[i];
                pa = q_addr[i]; pd = q_wdata[i]; ptag = q_tag[i];
            end else pv = 0;
        end
        nq = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int w = 0; w < DEPTH; w++) model[w] = '0;
        rst_n = 0; hsel = 0; htrans = 0; hwrite = 0; hsize = 0; haddr = 0; hwdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        check(hreadyout == 1'b1, "R10 ready after reset", hreadyout, 1);
        check(hrdata == '0, "R10 rdata after reset", hrdata, 0);
        // R10: stored words read zero after reset
        for (int w = 0; w < 4; w++) push(1, 2'b10, 0, 2, ADDR_W'(w*4), 0, "R10 reset content");
        flush();
        // R7: write then read same word back-to-back, then read before write
        push(1, 2'b10, 1, 2, 32'h8, 32'hA5A5_0001, "R7");
        push(1, 2'b11, 0, 2, 32'h8, 0, "R7 read after write");
        push(1, 2'b10, 0, 2, 32'h8, 0, "R7 read before write");
        push(1, 2'b10, 1, 2, 32'h8, 32'h1234_5678, "R7");
        push(1, 2'b10, 0, 2, 32'h8, 0, "R7 read new");
        flush();
        // R3 and R4: consecutive writes to different words, each stalled
        push(1, 2'b10, 1, 2, 32'h10, 32'h1111_1111, "R3");
        push(1, 2'b11, 1, 2, 32'h14, 32'h2222_2222, "R3");
        push(1, 2'b10, 0, 2, 32'h10, 0, "R3/R4 stalled write kept its address");
        push(1, 2'b10, 0, 2, 32'h14, 0, "R3/R4 second write");
        flush();
        // R2: IDLE, BUSY and deselected writes leave storage alone
        push(1, 2'b00, 1, 2, 32'h10, 32'hDEAD_0000, "R2");
        push(1, 2'b01, 1, 2, 32'h10, 32'hDEAD_0001, "R2");
        push(0, 2'b10, 1, 2, 32'h10, 32'hDEAD_0002, "R2");
        push(1, 2'b10, 0, 2, 32'h10, 0, "R2 storage unchanged");
        flush();
        // R8: byte and halfword lanes
        for (int l = 0; l < 4; l++)
            push(1, 2'b10, 1, 0, ADDR_W'(32'h20 + l), 32'h0101_0101 * (l + 2), "R8");
        push(1, 2'b10, 0, 2, 32'h20, 0, "R8 bytes");
        push(1, 2'b10, 1, 1, 32'h22, 32'hBEEF_CAFE, "R8");
        push(1, 2'b10, 0, 2, 32'h20, 0, "R8 halfword");
        flush();
        // R11: alias across the index range
        push(1, 2'b10, 1, 2, 32'h0000_0104, 32'h0BAD_F00D, "R11");
        push(1, 2'b10, 0, 2, 32'h0000_0004, 0, "R11 alias read");
        flush();
        // R1/R3/R6: constrained random traffic with every transfer type
        for (int k = 0; k < 300; k++) begin
            logic [2:0] z = 3'($urandom_range(0, 2));
            logic [ADDR_W-1:0] a = ADDR_W'($urandom_range(0, 4*DEPTH*2 - 1));
            logic [1:0] t = ($urandom_range(0, 9) < 2) ? 2'($urandom_range(0, 1))
                                                       : 2'($urandom_range(2, 3));
            a = a & ~((ADDR_W'(1) << z) - 1);
            push($urandom_range(0, 9) != 0, t, 1'($urandom), z, a, $urandom, "R1/R3/R6 random");
            if (nq == 100) flush();
        end
        flush();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule